// File: doc/BRIEF.md
# Recovered Byte Clock Generator

This block turns the recovered serial bit clock into a byte-rate clock and the two once-per-byte strobes that move received data through the receive path. A free-running bit counter sets the byte period. It counts 0 to 9 and wraps. The counter drives three outputs. The first is the byte clock, high for counts 0 to 4 and low for counts 5 to 9. The second is a one-cycle strobe that copies the shift register into the decode register. The third is a one-cycle strobe that updates the output register at the start of each byte clock high phase.

The framer raises a reframe request when it finds a byte boundary. The request restarts the counter at 0 on the next bit-clock edge. Downstream logic uses the byte clock as a real clock, so a restart may stretch a phase but must never shorten one. A four-state phase machine keeps this rule. It moves between PH_LO, PH_HI, PH_HI_EXT (high phase carried past a restart) and PH_LO_EXT (low phase carried past a skipped rising edge). A phase-age counter tells the machine whether the current level has lasted the minimum of five bit times.

The transitions are named as follows. T_RISE (PH_LO or PH_LO_EXT to PH_HI) happens when the next count is 0 and the low phase is old enough. T_SKIP_RISE (PH_LO to PH_LO_EXT) happens when the next count is 0 and the low phase is too young. T_STRETCH_HIGH (PH_HI to PH_HI_EXT) happens when a reframe arrives during a high phase. T_FALL (PH_HI or PH_HI_EXT to PH_LO) happens when the next count is 5 and the high phase is old enough.

Top module: `byte_clock_gen`

## Requirements
- R1: While reset is asserted, byte_clk, load_stb and upd_stb are 0. The counter restarts at count 0 with byte_clk low. byte_clk first rises 10 bit-clock cycles after reset is released.
- R2: With no reframe, the count advances by one every bit-clock cycle and wraps from 9 to 0. load_stb is high for exactly the one cycle in which the count is 9.
- R3: A reframe request that is high when a rising edge samples it makes the count 0 in the next cycle. The next load_stb comes 9 cycles after that. The interrupted partial byte gets no load_stb.
- R4: byte_clk rises only into a cycle whose count is 0. In steady operation it is high for counts 0 to 4 and low for counts 5 to 9.
- R5: upd_stb is high for exactly one cycle, the first cycle of every byte_clk high phase, and at no other time.
- R6: Whatever the reframe pattern, no byte_clk high phase or low phase lasts fewer than 5 cycles, and no rise-to-rise period is shorter than 10 cycles.
- R7: A reframe during a high phase keeps byte_clk high through count 4 of the restarted sequence. A reframe in the fifth high cycle gives a 10-cycle high phase.
- R8: A reframe during a low phase that has lasted fewer than 5 cycles skips the next rising edge. byte_clk stays low until count 0 of the following byte. For a reframe that is at least 22 cycles from any other, the low phase is at most 14 cycles and the period at most 19.
- R9: A reframe taken in the fifth low cycle (count 9) causes no stretch. byte_clk rises at the restarted count 0 with a 5-cycle low phase and a 10-cycle period.
- R10: From the first rise after a reframe, byte_clk again follows the restarted count as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reframe_req | input | 1 | Framer request to restart the bit count at 0 |
| byte_clk | output | 1 | Recovered byte-rate clock, glitch-free and never shortened |
| load_stb | output | 1 | One-cycle shift-to-decode-register transfer strobe (count 9) |
| upd_stb | output | 1 | One-cycle output-register update strobe at each byte_clk rise |

## Verification
The hardest case to reach is a reframe landing in the last cycles of a young low phase, the only path through T_SKIP_RISE, which produces the longest permitted period. Uniform random reframes rarely hit that exact count. The bench therefore tracks the count itself and times directed reframes to chosen counts: 2, 4, 6, 8 and 9. It then measures the phase and period lengths that follow. Random phases then mix widely spaced reframes, which are used to check the 19-cycle bound, with dense bursts that stack T_STRETCH_HIGH and PH_LO_EXT. During the bursts only the minimum-width and strobe-position rules are checked.

// File: rtl/byte_clock_pkg.sv
package byte_clock_pkg;

    // Byte clock phase states
    typedef enum logic [1:0] {
        PH_LO     = 2'd0,  // low, normal
        PH_HI     = 2'd1,  // high, normal
        PH_HI_EXT = 2'd2,  // high carried past a count restart
        PH_LO_EXT = 2'd3   // low carried past a skipped rising edge
    } phase_e;

    function automatic logic phase_is_high(input phase_e p);
        return (p == PH_HI) || (p == PH_HI_EXT);
    endfunction

endpackage

// File: rtl/bcg_bit_counter.sv
module bcg_bit_counter #(
    parameter int BITS_PER_BYTE = 10,
    parameter int HIGH_BITS     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reframe,
    output logic at_rise,   // next count is 0
    output logic at_fall,   // next count is HIGH_BITS
    output logic at_last    // next count is the final bit of the byte
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] FALL_CNT = CNT_W'(HIGH_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (reframe) begin
            cnt_d = '0;
        end else if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_rise = (cnt_d == '0);
    assign at_fall = (cnt_d == FALL_CNT);
    assign at_last = (cnt_d == LAST_CNT);

endmodule

// File: rtl/bcg_phase_age.sv
module bcg_phase_age #(
    parameter int MIN_PHASE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_change,
    output logic age_ok
);
    localparam int AGE_W = $clog2(MIN_PHASE + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_PHASE);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (level_change) begin
            age_q <= AGE_W'(1);
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    assign age_ok = (age_q == AGE_MAX);

endmodule

// File: rtl/bcg_phase_fsm.sv
module bcg_phase_fsm
    import byte_clock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reframe,
    input  logic at_rise,
    input  logic at_fall,
    input  logic age_ok,
    output logic level_change,
    output logic byte_clk,
    output logic upd_stb
);
    phase_e ph_q;
    phase_e ph_d;
    logic   rise_now;

    // Next-state logic
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_LO: begin
                if (at_rise) begin
                    ph_d = age_ok ? PH_HI : PH_LO_EXT;  // T_RISE / T_SKIP_RISE
                end
            end
            PH_LO_EXT: begin
                if (at_rise && age_ok) begin
                    ph_d = PH_HI;                       // T_RISE
                end
            end
            PH_HI: begin
                if (reframe) begin
                    ph_d = PH_HI_EXT;                   // T_STRETCH_HIGH
                end else if (at_fall && age_ok) begin
                    ph_d = PH_LO;                       // T_FALL
                end
            end
            PH_HI_EXT: begin
                if (at_fall && age_ok) begin
                    ph_d = PH_LO;                       // T_FALL
                end
            end
            default: ph_d = PH_LO;
        endcase
    end

    assign level_change = phase_is_high(ph_d) != phase_is_high(ph_q);
    assign rise_now     = phase_is_high(ph_d) && !phase_is_high(ph_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_LO;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_clk <= 1'b0;
            upd_stb  <= 1'b0;
        end else begin
            byte_clk <= phase_is_high(ph_d);
            upd_stb  <= rise_now;
        end
    end

endmodule

// File: rtl/bcg_load_strobe.sv
module bcg_load_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic at_last,
    output logic load_stb
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb <= 1'b0;
        end else begin
            load_stb <= at_last;
        end
    end
endmodule

// File: rtl/byte_clock_gen.sv
module byte_clock_gen #(
    parameter int BITS_PER_BYTE = 10,
    parameter int HIGH_BITS     = 5
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic reframe_req,
    output logic byte_clk,
    output logic load_stb,
    output logic upd_stb
);
    localparam int LOW_BITS  = BITS_PER_BYTE - HIGH_BITS;
    localparam int MIN_PHASE = (HIGH_BITS < LOW_BITS) ? HIGH_BITS : LOW_BITS;

    logic at_rise;
    logic at_fall;
    logic at_last;
    logic age_ok;
    logic level_change;

    bcg_bit_counter #(
        .BITS_PER_BYTE (BITS_PER_BYTE),
        .HIGH_BITS     (HIGH_BITS)
    ) u_cnt (
        .clk     (clk_bit),
        .rst_n   (rst_n),
        .reframe (reframe_req),
        .at_rise (at_rise),
        .at_fall (at_fall),
        .at_last (at_last)
    );

    bcg_phase_age #(
        .MIN_PHASE (MIN_PHASE)
    ) u_age (
        .clk          (clk_bit),
        .rst_n        (rst_n),
        .level_change (level_change),
        .age_ok       (age_ok)
    );

    bcg_phase_fsm u_fsm (
        .clk          (clk_bit),
        .rst_n        (rst_n),
        .reframe      (reframe_req),
        .at_rise      (at_rise),
        .at_fall      (at_fall),
        .age_ok       (age_ok),
        .level_change (level_change),
        .byte_clk     (byte_clk),
        .upd_stb      (upd_stb)
    );

    bcg_load_strobe u_ld (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .at_last  (at_last),
        .load_stb (load_stb)
    );

endmodule

// File: rtl/byte_clock_gen_chk.sv
module byte_clock_gen_chk #(
    parameter int BITS_PER_BYTE = 10,
    parameter int HIGH_BITS     = 5
) (
    input logic clk_bit,
    input logic rst_n,
    input logic reframe_req,
    input logic byte_clk,
    input logic load_stb,
    input logic upd_stb
);
    localparam int LOW_BITS  = BITS_PER_BYTE - HIGH_BITS;
    localparam int MIN_PHASE = (HIGH_BITS < LOW_BITS) ? HIGH_BITS : LOW_BITS;
    localparam int POS_W     = $clog2(BITS_PER_BYTE);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BITS_PER_BYTE - 1);
    localparam logic [4:0] MIN_RUN = 5'(MIN_PHASE);

    logic [POS_W-1:0] bpos;
    logic             prev_clk;
    logic [4:0]       run;

    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            bpos     <= '0;
            prev_clk <= 1'b0;
            run      <= '0;
        end else begin
            bpos     <= (reframe_req || bpos == POS_LAST) ? '0 : bpos + POS_W'(1);
            prev_clk <= byte_clk;
            if (byte_clk != prev_clk) begin
                run <= 5'd1;
            end else if (run != 5'd31) begin
                run <= run + 5'd1;
            end
        end
    end

    AST_HIGH_MIN: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (prev_clk && !byte_clk) |-> (run >= MIN_RUN)); // R6
    AST_LOW_MIN: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!prev_clk && byte_clk) |-> (run >= MIN_RUN)); // R6
    AST_LOAD_POS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_stb |-> (bpos == POS_LAST)); // R2
    AST_LOAD_DUE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (bpos == POS_LAST) |-> load_stb); // R3
    AST_RISE_AT_ZERO: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (byte_clk && !prev_clk) |-> (bpos == '0)); // R4
    AST_UPD_ON_RISE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        upd_stb |-> (byte_clk && !prev_clk)); // R5
    AST_RISE_HAS_UPD: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (byte_clk && !prev_clk) |-> upd_stb); // R5

endmodule

bind byte_clock_gen byte_clock_gen_chk #(
    .BITS_PER_BYTE (BITS_PER_BYTE),
    .HIGH_BITS     (HIGH_BITS)
) u_chk (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .reframe_req (reframe_req),
    .byte_clk    (byte_clk),
    .load_stb    (load_stb),
    .upd_stb     (upd_stb)
);

// File: tb/byte_clock_gen_tb_top.sv
`timescale 1ns/1ps
module byte_clock_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reframe_req = 1'b0;
    logic byte_clk;
    logic load_stb;
    logic upd_stb;

    always #5 clk = ~clk;

    byte_clock_gen dut_i (
        .clk_bit     (clk),
        .rst_n       (rst_n),
        .reframe_req (reframe_req),
        .byte_clk    (byte_clk),
        .load_stb    (load_stb),
        .upd_stb     (upd_stb)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model state
    int bcnt = 0;         // expected count in current cycle
    int now = 0;
    int since_align = 0;  // cycles since reset release or last reframe
    int t_rf_last = -1000;
    int t_cluster = -1000;
    logic prev_b = 1'b0;
    int run_b = 1;
    int since_rise = 0;
    bit have_rise = 1'b0;
    int hi_len_q = 0;
    int lo_len_q = 0;
    int per_q = 0;
    bit saw_rise = 1'b0;
    bit saw_fall = 1'b0;

    function automatic bit exp_load(input int c);
        return (c == 9);
    endfunction

    function automatic bit exp_clk(input int c);
        return (c < 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, now);
        end
    endtask

    task automatic observe();
        bit rise;
        bit fall;
        rise = byte_clk && !prev_b;
        fall = !byte_clk && prev_b;
        since_rise++;
        if (rise || fall) begin
            chk(run_b >= 5, "R6", run_b, 5);
            if (fall) begin
                hi_len_q = run_b;
                saw_fall = 1'b1;
            end else begin
                lo_len_q = run_b;
                saw_rise = 1'b1;
            end
            run_b = 1;
        end else begin
            run_b++;
        end
        if (rise) begin
            chk(bcnt == 0, "R4", bcnt, 0);
            if (have_rise) begin
                chk(since_rise >= 10, "R6", since_rise, 10);
                if (now - t_cluster > 40)
                    chk(since_rise <= 19, "R8", since_rise, 19);
            end
            per_q = since_rise;
            since_rise = 0;
            have_rise = 1'b1;
        end
        chk(load_stb == exp_load(bcnt), "R2", load_stb, exp_load(bcnt));
        chk(upd_stb == rise, "R5", upd_stb, rise);
        if (since_align >= 20)
            chk(byte_clk == exp_clk(bcnt), "R10", byte_clk, exp_clk(bcnt));
        prev_b = byte_clk;
    endtask

    task automatic tick(input bit rf);
        reframe_req = rf;
        @(negedge clk);
        now++;
        if (rf) begin
            if (now - t_rf_last < 22) t_cluster = now;
            t_rf_last = now;
            bcnt = 0;
            since_align = 0;
        end else begin
            bcnt = (bcnt == 9) ? 0 : bcnt + 1;
            since_align++;
        end
        reframe_req = 1'b0;
        observe();
    endtask

    task automatic wait_cnt(input int k);
        while (bcnt != k) tick(1'b0);
    endtask

    task automatic wait_rise();
        saw_rise = 1'b0;
        for (int i = 0; i < 40 && !saw_rise; i++) tick(1'b0);
    endtask

    task automatic wait_fall();
        saw_fall = 1'b0;
        for (int i = 0; i < 40 && !saw_fall; i++) tick(1'b0);
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(byte_clk == 1'b0, "R1", byte_clk, 0);
            chk(load_stb == 1'b0, "R1", load_stb, 0);
            chk(upd_stb == 1'b0, "R1", upd_stb, 0);
        end
        rst_n = 1'b1;
        bcnt = 0;
        since_align = 0;
        prev_b = 1'b0;
        run_b = 1;
        n = 0;
        while (!byte_clk && n < 30) begin
            tick(1'b0);
            n++;
        end
        chk(n == 10, "R1", n, 10);

        repeat (30) tick(1'b0);

        // R7: reframe in fifth high cycle -> 10-cycle high
        wait_cnt(4);
        tick(1'b1);
        wait_fall();
        chk(hi_len_q == 10, "R7", hi_len_q, 10);
        repeat (30) tick(1'b0);

        // R7 and R3: reframe in third high cycle -> 8-cycle high, load 9 cycles later
        wait_cnt(2);
        tick(1'b1);
        n = 0;
        while (!load_stb && n < 30) begin
            tick(1'b0);
            n++;
        end
        chk(n == 9, "R3", n, 9);
        chk(hi_len_q == 8, "R7", hi_len_q, 8);
        repeat (30) tick(1'b0);

        // R8: reframe in fourth low cycle -> low 14, period 19
        wait_cnt(8);
        tick(1'b1);
        wait_rise();
        chk(lo_len_q == 14, "R8", lo_len_q, 14);
        chk(per_q == 19, "R8", per_q, 19);
        repeat (30) tick(1'b0);

        // R8: reframe in second low cycle -> low 12, period 17
        wait_cnt(6);
        tick(1'b1);
        wait_rise();
        chk(lo_len_q == 12, "R8", lo_len_q, 12);
        chk(per_q == 17, "R8", per_q, 17);
        repeat (30) tick(1'b0);

        // R9: reframe at count 9 -> no stretch
        wait_cnt(9);
        tick(1'b1);
        wait_rise();
        chk(lo_len_q == 5, "R9", lo_len_q, 5);
        chk(per_q == 10, "R9", per_q, 10);
        repeat (30) tick(1'b0);

        // Held reframe: minimum widths only (R6)
        repeat (15) tick(1'b1);
        repeat (45) tick(1'b0);

        // Random isolated reframes (R8 bound, R10 realign)
        for (int i = 0; i < 40; i++) begin
            int gap;
            gap = $urandom_range(22, 45);
            repeat (gap) tick(1'b0);
            tick(1'b1);
        end
        repeat (45) tick(1'b0);

        // Random dense bursts (R6, R2, R3, R5)
        for (int i = 0; i < 400; i++) tick(($urandom % 3) == 0);
        repeat (45) tick(1'b0);

        for (int i = 0; i < 20; i++) begin
            repeat ($urandom_range(22, 35)) tick(1'b0);
            tick(1'b1);
        end
        repeat (45) tick(1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule